// File: doc/BRIEF.md
# Critical Data Side Buffer

This block is a small, fully associative word store placed next to the level-one data cache. It keeps the most recent words read by loads that the compiler marked ahead of time as critical loads that revisit the same address. Every load lookup is presented to it at the same time as to the cache. On a match it returns hit and the word in the same cycle, so the load pipeline can take the value from whichever path answers first.

Only hinted loads may place data in the buffer. When the memory system returns the data for such a load, it presents that data on the fill port with the hint set. Fills without the hint are dropped, so ordinary loads cannot pollute the buffer. The buffer never touches the cache's contents or replacement, and it has no aging or pinning scheme. Stores are snooped: a store to a held word merges its enabled bytes into the copy. Replacement is least recently used across all entries. Recency is refreshed by hinted fills and by hits of hinted loads.

Top module: `crit_side_buf`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and lk_data reads zero.
- R2: A fill with fill_hint low changes nothing: a later lookup of that word misses, and no resident word is displaced.
- R3: A hinted fill of a word that is not held allocates an entry. From the next cycle a lookup of that word hits and returns the fill data.
- R4: A lookup hits in the same cycle it is presented, whether lk_hint is high or low. lk_hit is low whenever lk_valid is low, and lk_data is zero on a miss.
- R5: Matching uses the word address only, which is address bits ADDR_W-1 down to 2. The two byte-offset bits are ignored.
- R6: A hinted fill of a word already held overwrites that entry's data. It does not create a second copy and evicts nothing.
- R7: Allocation uses the lowest-numbered invalid entry. When no entry is invalid, it uses the least recently used entry. Recency is refreshed only by hinted fills and by lookup hits with lk_hint high; unhinted lookups and stores leave it unchanged.
- R8: A store to a held word replaces byte b (data bits 8b+7 to 8b) where st_be[b] is 1 and keeps the other bytes. The change is visible from the next cycle, and the store does not refresh recency.
- R9: A store to a word that is not held allocates nothing.
- R10: When a hinted fill and a store address the same word in one cycle, the entry holds the fill data with the store's enabled bytes laid over it. A lookup in the same cycle as a store returns the contents from before that cycle.
- R11: When a hinted fill and a hinted lookup hit occur in the same cycle, the filled entry becomes the most recently used. The hit entry keeps its earlier position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Load lookup present |
| lk_addr | input | ADDR_W | Load byte address |
| lk_hint | input | 1 | Load carries the static critical hint |
| lk_hit | output | 1 | Lookup matched a held word (combinational) |
| lk_data | output | 32 | Matched word, zero on miss |
| fill_valid | input | 1 | Memory return present |
| fill_addr | input | ADDR_W | Byte address of the returned word |
| fill_hint | input | 1 | Returned word belongs to a hinted load |
| fill_data | input | 32 | Returned word |
| st_valid | input | 1 | Store snoop present |
| st_addr | input | ADDR_W | Store byte address |
| st_be | input | 4 | Store byte enables |
| st_data | input | 32 | Store data |

## Verification
The bench uses four entries and compares every lookup against a timestamp-based reference model. Directed steps fill the buffer, refresh entries with hinted lookups, leave others alone with unhinted lookups, and overflow it. Which word gets evicted separates true least-recently-used order from insertion order, and shows whether unhinted lookups and stores wrongly refresh recency. All sixteen byte-enable patterns are swept over one held word. Same-cycle fill-and-store and fill-and-hit cases separate the merge and priority rules. A long pseudo-random stream of mixed lookups, fills and stores over a six-word pool exceeds the capacity and exercises eviction, overwrite and snooping together.

// File: rtl/csb_pkg.sv
`timescale 1ns/1ps
package csb_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam int OFF_W  = $clog2(BE_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BE_W-1:0]   be_t;

  // Lay the enabled bytes of upd over base.
  function automatic word_t merge_bytes(word_t base, word_t upd, be_t be);
    word_t r;
    r = base;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[b*8 +: 8] = upd[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/csb_cam.sv
`timescale 1ns/1ps
module csb_cam #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]       valid,
  input  logic [ENTRIES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]         key,
  output logic [ENTRIES-1:0]       match,
  output logic [IDX_W-1:0]         idx
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/csb_free.sv
`timescale 1ns/1ps
module csb_free #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  output logic               has_free,
  output logic [IDX_W-1:0]   free_idx
);
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/csb_lru.sv
`timescale 1ns/1ps
module csb_lru #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  // rank 0 is most recent, ENTRIES-1 least recent; ranks form a permutation
  logic [IDX_W-1:0] rank_q [ENTRIES];
  logic [IDX_W-1:0] touch_rank;

  assign touch_rank = rank_q[touch_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(i))     rank_q[i] <= '0;
        else if (rank_q[i] < touch_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/crit_side_buf.sv
`timescale 1ns/1ps
module crit_side_buf
  import csb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hint,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_hint,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [BE_W-1:0]   st_be,
  input  logic [WORD_W-1:0] st_data
);
  logic [ENTRIES-1:0]       valid_q;
  logic [TAG_W-1:0]         tag_q  [ENTRIES];
  word_t                    data_q [ENTRIES];
  logic [ENTRIES*TAG_W-1:0] tag_flat;

  logic [TAG_W-1:0] lk_key, fill_key, st_key;
  logic [ENTRIES-1:0] lk_match, fill_match, st_match;
  logic [IDX_W-1:0] lk_idx, fill_hit_idx, st_idx;
  logic lk_any, fill_hit, st_hit;
  logic has_free;
  logic [IDX_W-1:0] free_idx, lru_victim;

  // named events for the checker
  logic             fill_go, fill_new, st_upd, touch_en;
  logic [IDX_W-1:0] fill_idx, touch_idx;
  word_t            fill_word;
  logic             unused_offsets;

  assign unused_offsets = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], st_addr[OFF_W-1:0]};

  assign lk_key   = lk_addr[ADDR_W-1:OFF_W];
  assign fill_key = fill_addr[ADDR_W-1:OFF_W];
  assign st_key   = st_addr[ADDR_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign tag_flat[i*TAG_W +: TAG_W] = tag_q[i];
  end

  csb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_cam (
    .valid(valid_q), .tags(tag_flat), .key(lk_key), .match(lk_match), .idx(lk_idx));
  csb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_fill_cam (
    .valid(valid_q), .tags(tag_flat), .key(fill_key), .match(fill_match), .idx(fill_hit_idx));
  csb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_st_cam (
    .valid(valid_q), .tags(tag_flat), .key(st_key), .match(st_match), .idx(st_idx));

  csb_free #(.ENTRIES(ENTRIES)) u_free (
    .valid(valid_q), .has_free(has_free), .free_idx(free_idx));

  csb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(lru_victim));

  assign lk_any   = |lk_match;
  assign fill_hit = |fill_match;
  assign st_hit   = |st_match;

  // lookup path, parallel with the cache
  assign lk_hit  = lk_valid && lk_any;
  assign lk_data = lk_hit ? data_q[lk_idx] : '0;

  // fill path: only hinted returns may allocate or overwrite
  assign fill_go  = fill_valid && fill_hint;
  assign fill_new = fill_go && !fill_hit;
  assign fill_idx = fill_hit ? fill_hit_idx : (has_free ? free_idx : lru_victim);
  assign fill_word = (st_valid && (st_key == fill_key))
                   ? merge_bytes(fill_data, st_data, st_be) : fill_data;

  // store snoop against current contents
  assign st_upd = st_valid && st_hit;

  // recency: a fill outranks a lookup hit in the same cycle
  assign touch_en  = fill_go || (lk_hit && lk_hint);
  assign touch_idx = fill_go ? fill_idx : lk_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end else if (fill_go && (fill_idx == IDX_W'(i))) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= fill_key;
        data_q[i]  <= fill_word;
      end else if (st_upd && (st_idx == IDX_W'(i))) begin
        data_q[i]  <= merge_bytes(data_q[i], st_data, st_be);
      end
    end
  end
endmodule

// File: rtl/csb_checker.sv
`timescale 1ns/1ps
module csb_checker #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] valid_q,
  input logic               fill_valid,
  input logic               fill_hint,
  input logic               fill_hit,
  input logic               fill_new,
  input logic               has_free,
  input logic               touch_en,
  input logic [IDX_W-1:0]   touch_idx,
  input logic [IDX_W-1:0]   lru_victim
);
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid); // R4
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R6
  AST_UNHINTED_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_hint) |=> $countones(valid_q) == $past($countones(valid_q))); // R2
  AST_OVERWRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_hint && fill_hit) |=> $countones(valid_q) == $past($countones(valid_q))); // R6
  AST_NEW_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_new && has_free) |=> $countones(valid_q) == $past($countones(valid_q)) + 1); // R3
  AST_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> lru_victim != $past(touch_idx)); // R7
endmodule

bind crit_side_buf csb_checker #(.ENTRIES(ENTRIES)) u_csb_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_match(lk_match), .valid_q(valid_q), .fill_valid(fill_valid),
  .fill_hint(fill_hint), .fill_hit(fill_hit), .fill_new(fill_new),
  .has_free(has_free), .touch_en(touch_en), .touch_idx(touch_idx),
  .lru_victim(lru_victim));

// File: tb/test_crit_side_buf.sv
`timescale 1ns/1ps
module test_crit_side_buf;
  localparam int AW = 12;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_hint = 0, fill_valid = 0, fill_hint = 0, st_valid = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0, st_addr = '0;
  logic [31:0] fill_data = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic        lk_hit;
  logic [31:0] lk_data;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crit_side_buf #(.ADDR_W(AW), .ENTRIES(N)) i_crit_side_buf (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hint(lk_hint),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_hint(fill_hint),
    .fill_data(fill_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be), .st_data(st_data));

  // reference model: timestamps give recency order
  bit          mval [N];
  int unsigned mtag [N];
  logic [31:0] mdata [N];
  longint      mts [N];
  longint      now = 0;

  function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic int mfind(logic [AW-1:0] a);
    for (int i = 0; i < N; i++)
      if (mval[i] && mtag[i] == int'(a >> 2)) return i;
    return -1;
  endfunction

  function automatic int mvictim();
    int v;
    for (int i = 0; i < N; i++) if (!mval[i]) return i;
    v = 0;
    for (int i = 1; i < N; i++) if (mts[i] < mts[v]) v = i;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(bit lv, logic [AW-1:0] la, bit lh,
                       bit fv, logic [AW-1:0] fa, bit fh, logic [31:0] fd,
                       bit sv, logic [AW-1:0] sa, logic [3:0] sbe, logic [31:0] sd,
                       string req);
    int li, fi, si;
    logic [31:0] fw;
    lk_valid = lv; lk_addr = la; lk_hint = lh;
    fill_valid = fv; fill_addr = fa; fill_hint = fh; fill_data = fd;
    st_valid = sv; st_addr = sa; st_be = sbe; st_data = sd;
    #1;
    li = lv ? mfind(la) : -1;
    if (lv) begin
      check(lk_hit == (li >= 0), req, 64'(lk_hit), 64'(li >= 0));
      check(lk_data == ((li >= 0) ? mdata[li] : 32'h0), req, 64'(lk_data),
            64'((li >= 0) ? mdata[li] : 32'h0));
    end else begin
      check(lk_hit == 1'b0, "R4", 64'(lk_hit), 64'(0));
    end
    si = sv ? mfind(sa) : -1;
    fi = -1;
    if (fv && fh) begin
      fi = mfind(fa);
      if (fi < 0) fi = mvictim();
    end
    fw = (sv && (sa >> 2) == (fa >> 2)) ? bmerge(fd, sd, sbe) : fd;
    if (si >= 0 && si != fi) mdata[si] = bmerge(mdata[si], sd, sbe);
    if (fi >= 0) begin
      mval[fi] = 1; mtag[fi] = int'(fa >> 2); mdata[fi] = fw; mts[fi] = now;
    end else if (li >= 0 && lh) begin
      mts[li] = now;
    end
    now++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(logic [AW-1:0] a, bit h, string req);
    cycle(1, a, h, 0, '0, 0, '0, 0, '0, '0, '0, req);
  endtask
  task automatic fill(logic [AW-1:0] a, logic [31:0] d, bit h, string req);
    cycle(0, '0, 0, 1, a, h, d, 0, '0, '0, '0, req);
  endtask
  task automatic store(logic [AW-1:0] a, logic [3:0] be, logic [31:0] d, string req);
    cycle(0, '0, 0, 0, '0, 0, '0, 1, a, be, d, req);
  endtask

  // explicit port check of a word, sampled mid-cycle
  task automatic expect_word(logic [AW-1:0] a, bit hit, logic [31:0] d, string req);
    lk_valid = 1; lk_addr = a; lk_hint = 0;
    fill_valid = 0; st_valid = 0;
    #1;
    check(lk_hit == hit, req, 64'(lk_hit), 64'(hit));
    check(lk_data == (hit ? d : 32'h0), req, 64'(lk_data), 64'(hit ? d : 32'h0));
    lk_valid = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    int unsigned s;
    for (int i = 0; i < N; i++) begin mval[i] = 0; mtag[i] = 0; mdata[i] = 0; mts[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    expect_word(12'h000, 0, 0, "R1");
    expect_word(12'hFFC, 0, 0, "R1");
    peek(12'h040, 1, "R1");

    // R2 unhinted fill ignored
    fill(12'h040, 32'h1111_1111, 0, "R2");
    expect_word(12'h040, 0, 0, "R2");

    // R3 hinted allocation
    fill(12'h040, 32'hA000_0040, 1, "R3");
    fill(12'h080, 32'hA000_0080, 1, "R3");
    fill(12'h0C0, 32'hA000_00C0, 1, "R3");
    fill(12'h100, 32'hA000_0100, 1, "R3");
    expect_word(12'h040, 1, 32'hA000_0040, "R3");
    expect_word(12'h100, 1, 32'hA000_0100, "R3");
    // R2 unhinted fill of a new word while full evicts nothing
    fill(12'h140, 32'h2222_2222, 0, "R2");
    expect_word(12'h040, 1, 32'hA000_0040, "R2");
    expect_word(12'h140, 0, 0, "R2");

    // R5 byte offsets ignored; R4 unhinted and idle lookups
    expect_word(12'h081, 1, 32'hA000_0080, "R5");
    expect_word(12'h083, 1, 32'hA000_0080, "R5");
    peek(12'h0C2, 0, "R4");
    cycle(0, 12'h0C0, 1, 0, '0, 0, '0, 0, '0, '0, '0, "R4");

    // R6 overwrite of a held word
    fill(12'h080, 32'hB000_0080, 1, "R6");
    expect_word(12'h080, 1, 32'hB000_0080, "R6");
    expect_word(12'h040, 1, 32'hA000_0040, "R6");
    expect_word(12'h0C0, 1, 32'hA000_00C0, "R6");
    expect_word(12'h100, 1, 32'hA000_0100, "R6");

    // R7 LRU: order oldest first is 040,0C0,100,080
    peek(12'h040, 1, "R7");
    peek(12'h0C0, 0, "R7");
    fill(12'h200, 32'hA000_0200, 1, "R7");
    expect_word(12'h0C0, 0, 0, "R7");
    expect_word(12'h040, 1, 32'hA000_0040, "R7");

    // R8 byte-enable sweep on 0x040
    cur = 32'hA000_0040;
    for (int be = 0; be < 16; be++) begin
      logic [31:0] sd;
      sd = 32'h5A00_0000 ^ (32'h0101_0101 * be) ^ {be[3:0], 28'h0};
      store(12'h040, be[3:0], sd, "R8");
      cur = bmerge(cur, sd, be[3:0]);
      expect_word(12'h040, 1, cur, "R8");
    end
    // R8 store does not refresh: 100 is oldest
    store(12'h100, 4'hF, 32'hC000_0100, "R8");
    fill(12'h300, 32'hA000_0300, 1, "R8");
    expect_word(12'h100, 0, 0, "R8");

    // R9 store to an absent word
    store(12'h500, 4'hF, 32'hDEAD_BEEF, "R9");
    expect_word(12'h500, 0, 0, "R9");

    // R10 fill and store to the same word in one cycle
    cycle(0, '0, 0, 1, 12'h600, 1, 32'h1234_5678, 1, 12'h602, 4'b0101, 32'hAABB_CCDD, "R10");
    expect_word(12'h600, 1, 32'h12BB_56DD, "R10");
    // R10 lookup sees pre-store contents
    cycle(1, 12'h200, 0, 0, '0, 0, '0, 1, 12'h200, 4'hF, 32'h0F0F_0F0F, "R10");
    expect_word(12'h200, 1, 32'h0F0F_0F0F, "R10");

    // R11 fill beats a hinted hit for recency
    cycle(1, 12'h300, 1, 1, 12'h700, 1, 32'hA000_0700, 0, '0, '0, '0, "R11");
    fill(12'h740, 32'hA000_0740, 1, "R11");
    fill(12'h780, 32'hA000_0780, 1, "R11");
    expect_word(12'h700, 1, 32'hA000_0700, "R11");
    peek(12'h300, 0, "R11");

    // pseudo-random sweep over six words against the model
    s = 32'h1357_9BDF;
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a0, a1, a2;
      s = s * 1664525 + 1013904223;
      a0 = 12'h400 + 12'((s >> 4) % 6) * 4 + 12'(s[1:0]);
      a1 = 12'h400 + 12'((s >> 9) % 6) * 4;
      a2 = 12'h400 + 12'((s >> 14) % 6) * 4 + 12'(s[3:2]);
      cycle(s[20], a0, s[21], s[22] & s[23], a1, s[24] | s[25], s ^ 32'h0F1E_2D3C,
            s[26] & s[27], a2, 4'(s >> 28), ~s, "R7 R8 R10 sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule